// File: doc/BRIEF.md
# Training Word Generator and Edge-Masked Group Checker

This block feeds a memory read-training loop. It supplies a stream of 8-bit pseudo-random words that a controller writes into memory. It also checks the bytes captured on the read side against the same stream. Two copies of one maximal-length shift-register generator start from a shared seed. The transmit copy moves one step each time the writer asks for a new word. The receive copy moves one step each time a captured byte arrives. Because a restart reloads both copies together, the writer and the checker always follow the same sequence.

Only half of each byte takes part in the comparison. One input selects the clock edge being trained. When it selects the falling edge, the odd bit positions are compared. When it selects the rising edge, the even bit positions are compared. Errors in the other half have no effect on the result.

Captured bytes are counted in groups of eight, one group per delay setting. After the eighth byte, the block pulses a done flag for one cycle. At the same time it updates a pass flag, which is set only if every byte in the group matched. The controller uses the pass flag to step its delay search.

Top module: `prbs8_train_pat`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_word` equals the parameter `RST_SEED` (default 8'hA5), and `grp_done` and `grp_pass` are 0.
- R2: A cycle with `tx_adv` high and `restart` low changes `tx_word` from s to {s[6:0], s[7]^s[5]^s[4]^s[3]} (polynomial x^8+x^6+x^5+x^4+1). When `tx_adv` is low, `tx_word` holds. `tx_word` is never zero.
- R3: A cycle with `restart` high loads `seed_i` into both the transmit and receive generators, so `tx_word` equals `seed_i` in the next cycle. A zero `seed_i` is replaced by `RST_SEED`. `restart` has priority over `tx_adv` and `rx_valid`: the byte presented in that cycle is not counted.
- R4: Each cycle with `rx_valid` high is compared against the receive generator's current word. The receive generator then steps by the rule in R2. It does not depend on `tx_adv`.
- R5: With `edge_rise` = 0, only bits 7, 5, 3 and 1 (mask 8'hAA) are compared. A difference in bits 6, 4, 2 or 0 does not affect the result.
- R6: With `edge_rise` = 1, only bits 6, 4, 2 and 0 (mask 8'h55) are compared. A difference in the odd bits does not affect the result. The mask is chosen per byte, in the cycle that byte is presented.
- R7: `grp_done` is high for exactly one cycle: the cycle after every eighth counted byte since reset, restart or the previous group. At all other times it is low.
- R8: `grp_pass` is set in that same cycle to 1 only if all eight bytes of the group matched under their masks. It then holds until the next group completes.
- R9: `restart` clears `grp_pass`, `grp_done` and any partly counted group in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Reload both generators from the seed and clear the group state |
| seed_i | input | 8 | Seed used on restart (zero replaced by RST_SEED) |
| tx_adv | input | 1 | Advance the transmit word |
| tx_word | output | 8 | Current word to write |
| rx_valid | input | 1 | Captured byte present |
| rx_byte | input | 8 | Captured byte |
| edge_rise | input | 1 | 0: compare odd bits; 1: compare even bits |
| grp_done | output | 1 | One-cycle pulse after the eighth byte of a group |
| grp_pass | output | 1 | All eight bytes of the last group matched |

## Verification
The bench corrupts a single bit inside an otherwise clean group. It uses both an odd and an even position, under both edge selections. A design with the masks swapped or missing would then fail a group that should pass, or pass one that should fail. The bench also spaces captured bytes with idle cycles while `tx_adv` toggles independently. A design that tied the receive generator to the write strobe, or that counted idle cycles, would drift out of step with the expected words. Restarts are issued mid-group, together with a valid byte, and with a zero seed. A design that kept a partial count, counted the restart byte, or loaded zero into the generators would signal `grp_done` at the wrong cycle or lock `tx_word` at zero.

// File: rtl/prbs8_train_pkg.sv
package prbs8_train_pkg;

   localparam int unsigned PRBS_W = 8;
   // feedback taps for x^8+x^6+x^5+x^4+1 on state bits 7,5,4,3
   localparam logic [PRBS_W-1:0] PRBS_TAPS = 8'hB8;

   typedef logic [PRBS_W-1:0] prbs_word_t;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } train_edge_e;

   function automatic prbs_word_t prbs_advance(input prbs_word_t cur);
      return {cur[PRBS_W-2:0], ^(cur & PRBS_TAPS)};
   endfunction

endpackage

// File: rtl/prbs8_lfsr.sv
module prbs8_lfsr
   import prbs8_train_pkg::*;
#(
   parameter prbs_word_t RST_SEED = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  prbs_word_t load_val,
   input  logic       step,
   output prbs_word_t state
);

   prbs_word_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RST_SEED;
      end else if (load) begin
         state_q <= load_val;
      end else if (step) begin
         state_q <= prbs_advance(state_q);
      end
   end

   assign state = state_q;

endmodule

// File: rtl/edge_mask_cmp.sv
module edge_mask_cmp #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] got,
   input  logic [W-1:0] want,
   input  logic         edge_rise,
   output logic         match
);

   logic [W-1:0] odd_mask;
   logic [W-1:0] even_mask;
   logic [W-1:0] sel_mask;

   for (genvar b = 0; b < W; b++) begin : g_mask
      if ((b % 2) == 1) begin : g_odd
         assign odd_mask[b]  = 1'b1;
         assign even_mask[b] = 1'b0;
      end else begin : g_even
         assign odd_mask[b]  = 1'b0;
         assign even_mask[b] = 1'b1;
      end
   end

   assign sel_mask = edge_rise ? even_mask : odd_mask;
   assign match    = ((got ^ want) & sel_mask) == '0;

endmodule

// File: rtl/group_acc.sv
module group_acc #(
   parameter int unsigned GROUP_LEN = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic valid,
   input  logic match,
   output logic done,
   output logic pass
);

   localparam int unsigned CW = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(GROUP_LEN - 1);
   localparam bit POW2 = (GROUP_LEN & (GROUP_LEN - 1)) == 0;

   logic [CW-1:0] cnt_q;
   logic          acc_q;
   logic          done_q;
   logic          pass_q;
   logic          at_last;

   if (POW2) begin : g_wrap
      assign at_last = &cnt_q;
   end else begin : g_cmp
      assign at_last = (cnt_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= 1'b1;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         acc_q  <= 1'b1;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (valid) begin
            if (at_last) begin
               cnt_q  <= '0;
               acc_q  <= 1'b1;
               done_q <= 1'b1;
               pass_q <= acc_q & match;
            end else begin
               cnt_q <= cnt_q + 1'b1;
               acc_q <= acc_q & match;
            end
         end
      end
   end

   assign done = done_q;
   assign pass = pass_q;

endmodule

// File: rtl/prbs8_train_pat.sv
module prbs8_train_pat
   import prbs8_train_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter int unsigned GROUP_LEN = 8,
   parameter logic [7:0]  RST_SEED  = 8'hA5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] seed_i,
   input  logic         tx_adv,
   output logic [W-1:0] tx_word,
   input  logic         rx_valid,
   input  logic [W-1:0] rx_byte,
   input  logic         edge_rise,
   output logic         grp_done,
   output logic         grp_pass
);

   if (W != PRBS_W) begin : g_bad_w
      $error("prbs8_train_pat: W must equal the generator width");
   end
   if (GROUP_LEN < 2) begin : g_bad_len
      $error("prbs8_train_pat: GROUP_LEN must be at least 2");
   end
   if (RST_SEED == 8'h00) begin : g_bad_seed
      $error("prbs8_train_pat: RST_SEED must be nonzero");
   end

   prbs_word_t load_word;
   prbs_word_t tx_state;
   prbs_word_t rx_expect;
   logic       byte_ok;
   logic       count_byte;

   assign load_word  = (seed_i == '0) ? RST_SEED : seed_i;
   assign count_byte = rx_valid & ~restart;

   prbs8_lfsr #(.RST_SEED(RST_SEED)) u_tx_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (restart),
      .load_val (load_word),
      .step     (tx_adv),
      .state    (tx_state)
   );

   prbs8_lfsr #(.RST_SEED(RST_SEED)) u_rx_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (restart),
      .load_val (load_word),
      .step     (rx_valid),
      .state    (rx_expect)
   );

   edge_mask_cmp #(.W(W)) u_cmp (
      .got       (rx_byte),
      .want      (rx_expect),
      .edge_rise (edge_rise),
      .match     (byte_ok)
   );

   group_acc #(.GROUP_LEN(GROUP_LEN)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (restart),
      .valid (count_byte),
      .match (byte_ok),
      .done  (grp_done),
      .pass  (grp_pass)
   );

   assign tx_word = tx_state;

endmodule

// File: rtl/prbs8_train_pat_chk.sv
module prbs8_train_pat_chk #(
   parameter int unsigned W         = 8,
   parameter int unsigned GROUP_LEN = 8,
   parameter logic [7:0]  RST_SEED  = 8'hA5
) (
   input logic         clk,
   input logic         rst_n,
   input logic         restart,
   input logic [W-1:0] seed_i,
   input logic         tx_adv,
   input logic [W-1:0] tx_word,
   input logic         rx_valid,
   input logic         grp_done,
   input logic         grp_pass
);

   localparam int unsigned CW = $clog2(GROUP_LEN + 1);

   logic [CW-1:0] seen_q;
   logic          last_byte;

   assign last_byte = rx_valid && !restart && (seen_q == CW'(GROUP_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (restart) begin
         seen_q <= '0;
      end else if (rx_valid) begin
         seen_q <= last_byte ? '0 : seen_q + 1'b1;
      end
   end

   assert_tx_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_word != '0);

   assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !tx_adv) |=> $stable(tx_word));

   assert_seed_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> tx_word == (($past(seed_i) == '0) ? RST_SEED : $past(seed_i)));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_done |=> !grp_done);

   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> grp_done);

   assert_no_early_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !last_byte |=> !grp_done);

   assert_pass_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !last_byte) |=> $stable(grp_pass));

   assert_restart_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!grp_done && !grp_pass));

endmodule

bind prbs8_train_pat prbs8_train_pat_chk #(
   .W         (W),
   .GROUP_LEN (GROUP_LEN),
   .RST_SEED  (RST_SEED)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .seed_i   (seed_i),
   .tx_adv   (tx_adv),
   .tx_word  (tx_word),
   .rx_valid (rx_valid),
   .grp_done (grp_done),
   .grp_pass (grp_pass)
);

// File: tb/sim_prbs8_train_pat.sv
`timescale 1ns/1ps
module sim_prbs8_train_pat;

   localparam logic [7:0] RST_SEED = 8'hA5;
   localparam int LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       restart = 1'b0;
   logic [7:0] seed_i = 8'h00;
   logic       tx_adv = 1'b0;
   logic [7:0] tx_word;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       edge_rise = 1'b0;
   logic       grp_done;
   logic       grp_pass;

   always #2.5 clk = ~clk;

   prbs8_train_pat u0 (
      .clk(clk), .rst_n(rst_n), .restart(restart), .seed_i(seed_i),
      .tx_adv(tx_adv), .tx_word(tx_word), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .edge_rise(edge_rise),
      .grp_done(grp_done), .grp_pass(grp_pass)
   );

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string cur_tag = "R1";

   // behavioural reference state
   logic [7:0] m_tx, m_rx;
   int         m_cnt;
   bit         m_acc, m_done, m_pass;

   function automatic logic [7:0] nxt(input logic [7:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_tx = RST_SEED; m_rx = RST_SEED; m_cnt = 0;
         m_acc = 1; m_done = 0; m_pass = 0;
      end else if (restart) begin
         m_tx = (seed_i == 0) ? RST_SEED : seed_i;
         m_rx = m_tx; m_cnt = 0; m_acc = 1; m_done = 0; m_pass = 0;
      end else begin
         logic [7:0] msk;
         bit ok;
         if (tx_adv) m_tx = nxt(m_tx);
         m_done = 0;
         if (rx_valid) begin
            msk = edge_rise ? 8'h55 : 8'hAA;
            ok = ((rx_byte ^ m_rx) & msk) == 0;
            m_rx = nxt(m_rx);
            if (m_cnt == 7) begin
               m_done = 1; m_pass = m_acc && ok; m_cnt = 0; m_acc = 1;
            end else begin
               m_acc = m_acc && ok; m_cnt++;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmp_model();
      chk({cur_tag, " tx_word"}, tx_word, m_tx);
      chk({cur_tag, " grp_done"}, {7'd0, grp_done}, {7'd0, m_done});
      chk({cur_tag, " grp_pass"}, {7'd0, grp_pass}, {7'd0, m_pass});
   endtask

   task automatic cyc(input bit adv, input bit vld, input logic [7:0] err,
                      input bit edg, input bit rs, input logic [7:0] sd);
      @(negedge clk);
      cmp_model();
      tx_adv = adv; rx_valid = vld; edge_rise = edg;
      rx_byte = m_rx ^ err; restart = rs; seed_i = sd;
   endtask

   task automatic idle();
      cyc(0, 0, 8'h00, edge_rise, 0, 8'h00);
   endtask

   task automatic post(input string tag, input bit exp_pass);
      @(negedge clk);
      cmp_model();
      chk({tag, " done"}, {7'd0, grp_done}, 8'd1);
      chk({tag, " pass"}, {7'd0, grp_pass}, {7'd0, exp_pass});
      tx_adv = 0; rx_valid = 0; restart = 0;
   endtask

   task automatic group(input bit edg, input int bad_idx, input logic [7:0] bad,
                        input bit gaps);
      for (int i = 0; i < 8; i++) begin
         if (gaps && i > 0) cyc(i % 2, 0, 8'h00, edg, 0, 8'h00);
         cyc(i % 3 == 0, 1, (i == bad_idx) ? bad : 8'h00, edg, 0, 8'h00);
      end
   endtask

   always @(posedge clk) cycles++;

   initial begin : watchdog
      wait (cycles >= LIMIT);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      cur_tag = "R1";
      chk("R1 tx_word in reset", tx_word, RST_SEED);
      chk("R1 done in reset", {7'd0, grp_done}, 8'd0);
      chk("R1 pass in reset", {7'd0, grp_pass}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx_word after reset", tx_word, RST_SEED);

      // R3 seed load, then R2 stepping with holds
      cur_tag = "R3";
      cyc(0, 0, 8'h00, 0, 1, 8'h3C);
      @(negedge clk);
      chk("R3 seed loaded", tx_word, 8'h3C);
      cmp_model();
      cur_tag = "R2";
      for (int i = 0; i < 30; i++) cyc(i % 4 != 3, 0, 8'h00, 0, 0, 8'h00);
      idle();
      @(negedge clk);
      chk("R2 first step of 8'h01", nxt(8'h01), 8'h02);
      cmp_model();

      // R4 and R8: clean group, bytes spaced, tx_adv independent
      cur_tag = "R4";
      group(0, -1, 8'h00, 1);
      post("R8 clean falling group", 1);
      // R5 even-bit error ignored, odd-bit error fails
      cur_tag = "R5";
      group(0, 3, 8'h01, 0);
      post("R5 even error ignored", 1);
      group(0, 5, 8'h80, 0);
      post("R5 odd error detected", 0);
      group(0, 0, 8'h55, 1);
      post("R5 all even bits wrong", 1);
      // R6 rising edge
      cur_tag = "R6";
      group(1, 2, 8'h02, 0);
      post("R6 odd error ignored", 1);
      group(1, 7, 8'h04, 0);
      post("R6 even error detected", 0);
      group(1, 1, 8'hAA, 1);
      post("R6 all odd bits wrong", 1);

      // R9 restart mid group, with a valid byte in the restart cycle
      cur_tag = "R9";
      for (int i = 0; i < 5; i++) cyc(0, 1, 8'hFF, 0, 0, 8'h00);
      cyc(1, 1, 8'hFF, 0, 1, 8'h77);
      @(negedge clk);
      chk("R9 pass cleared", {7'd0, grp_pass}, 8'd0);
      chk("R9 done clear", {7'd0, grp_done}, 8'd0);
      chk("R3 restart beats tx_adv", tx_word, 8'h77);
      cmp_model();
      cur_tag = "R7";
      for (int i = 0; i < 7; i++) cyc(0, 1, 8'h00, 0, 0, 8'h00);
      idle();
      chk("R7 no done after seven", {7'd0, grp_done}, 8'd0);
      cyc(0, 1, 8'h00, 0, 0, 8'h00);
      post("R7 done after eighth", 1);
      idle();
      chk("R7 done lasts one cycle", {7'd0, grp_done}, 8'd0);
      chk("R8 pass holds", {7'd0, grp_pass}, 8'd1);

      // R3 zero seed substitution
      cur_tag = "R3";
      cyc(0, 0, 8'h00, 0, 1, 8'h00);
      @(negedge clk);
      chk("R3 zero seed replaced", tx_word, RST_SEED);
      cmp_model();

      // mixed traffic, edge changes mid group
      cur_tag = "R4 R6 mixed";
      for (int i = 0; i < 2000; i++) begin
         logic [7:0] e;
         e = ($urandom % 10 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
         cyc($urandom % 2, $urandom % 3 != 0, e, $urandom % 2,
             $urandom % 300 == 0, 8'($urandom));
      end
      idle();
      idle();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule